// File: doc/BRIEF.md
# Ripple-Carry Twelve-Function Arithmetic-Logic Unit

This is a purely combinational arithmetic-logic unit of parameterizable width `N` (any `N` of 1 or more). It takes two operands, a three-bit function select and a carry input. It returns an `N`-bit result and a carry output.

Selects 0 to 3 are arithmetic, and the carry input picks between two neighbouring variants of each (for example decrement or plain transfer). Selects 4 to 7 are bitwise, and for them the carry input is ignored.

The datapath is `N` identical one-bit slices. Each slice holds a full adder and two small input-forming gates. The carry output of each slice feeds the carry input of the next. A single decode stage turns the select lines into control terms that every slice shares.

For the arithmetic selects, the adder's first input is the A bit. Its second input is built from B bit gating: none, B, the inverse of B, or all ones.

For the bitwise selects:
- Each slice's carry input is forced to zero.
- A bit-fold term feeds B, or the inverse of B, into the first adder input.
- The adder sum then yields OR, XOR, AND or complement.

Top module: `rc_alu`

## Requirements
- R1: Select 3'b000 gives result = A when carry_in is 0 and A+1 (mod 2^N) when carry_in is 1; an all-ones A with carry_in 1 gives a zero result and carry_out 1.
- R2: Select 3'b001 gives A+B when carry_in is 0 and A+B+1 when carry_in is 1, modulo 2^N.
- R3: Select 3'b010 gives A-B-1 (A plus the ones' complement of B) when carry_in is 0 and A-B when carry_in is 1, modulo 2^N.
- R4: Select 3'b011 gives A-1 when carry_in is 0 and A unchanged when carry_in is 1, modulo 2^N.
- R5: Select 3'b100 gives the bitwise OR of A and B, whatever the value of carry_in.
- R6: Select 3'b101 gives the bitwise XOR of A and B, whatever the value of carry_in.
- R7: Select 3'b110 gives the bitwise AND of A and B, whatever the value of carry_in.
- R8: Select 3'b111 gives the bitwise complement of A, whatever the value of carry_in.
- R9: For selects 3'b000 to 3'b011, carry_out is bit N of the (N+1)-bit sum A + Y + carry_in. Here Y is 0, B, the ones' complement of B, or all ones for those four selects in that order. For selects 3'b100 to 3'b111, carry_out carries no meaning.
- R10: The block works at any width N of 1 or more, including a single slice.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | N | Operand A |
| opb | input | N | Operand B |
| sel | input | 3 | Function select (3'b000 to 3'b111) |
| carry_in | input | 1 | Carry into slice 0; picks the arithmetic variant |
| result | output | N | Function result F |
| carry_out | output | 1 | Carry out of the top slice |

## Verification
The bench builds three copies of the unit side by side: N = 1, N = 4 and N = 16. The 4-bit copy is driven through every combination of operand, select and carry, and so are the low bits that the 1-bit copy sees. This brings the single-slice chain and every carry wrap of a short chain within reach, including all-ones increment and zero decrement. The 16-bit copy receives random operands on top, which exercises long ripple paths and bitwise results across a wide word.

// File: rtl/rc_alu_pkg.sv
package rc_alu_pkg;

    // Function select encoding; values matter (sel[2] splits arithmetic from bitwise).
    typedef enum logic [2:0] {
        SEL_XFER_INC = 3'b000,
        SEL_ADD      = 3'b001,
        SEL_SUB      = 3'b010,
        SEL_DEC      = 3'b011,
        SEL_OR       = 3'b100,
        SEL_XOR      = 3'b101,
        SEL_AND      = 3'b110,
        SEL_NOT      = 3'b111
    } alu_sel_e;

    // Control terms shared by every slice.
    typedef struct packed {
        logic arith_en; // lets the ripple carry into the adder
        logic pass_b;   // B into the second adder input
        logic pass_nb;  // inverse B into the second adder input
        logic fold_b;   // B ORed into the first adder input
        logic fold_nb;  // inverse B ORed into the first adder input
    } slice_ctl_t;

endpackage

// File: rtl/rc_alu_decode.sv
module rc_alu_decode
    import rc_alu_pkg::*;
(
    input  logic [2:0]  sel,
    output slice_ctl_t  ctl
);

    logic ns0, ns1, ns2;

    always_comb begin
        ns0 = ~sel[0];
        ns1 = ~sel[1];
        ns2 = ~sel[2];
        ctl.arith_en = ns2;
        ctl.pass_b   = sel[0];
        ctl.pass_nb  = sel[1];
        ctl.fold_b   = sel[2] & ns1 & ns0;   // OR function
        ctl.fold_nb  = sel[2] & sel[1] & ns0; // AND function
    end

endmodule

// File: rtl/rc_alu_slice.sv
module rc_alu_slice
    import rc_alu_pkg::*;
(
    input  logic        a,
    input  logic        b,
    input  logic        ci,
    input  slice_ctl_t  ctl,
    output logic        f,
    output logic        co
);

    logic x, y, c;

    always_comb begin
        x  = a | (b & ctl.fold_b) | (~b & ctl.fold_nb);
        y  = (b & ctl.pass_b) | (~b & ctl.pass_nb);
        c  = ci & ctl.arith_en;
        f  = x ^ y ^ c;
        co = (x & y) | (x & c) | (y & c);
    end

endmodule

// File: rtl/rc_alu.sv
module rc_alu
    import rc_alu_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0] opa,
    input  logic [N-1:0] opb,
    input  logic [2:0]   sel,
    input  logic         carry_in,
    output logic [N-1:0] result,
    output logic         carry_out
);

    localparam int CHAIN = N + 1;

    slice_ctl_t         ctl;
    logic [CHAIN-1:0]   cy;

    rc_alu_decode u_dec (
        .sel (sel),
        .ctl (ctl)
    );

    assign cy[0] = carry_in;

    for (genvar i = 0; i < N; i++) begin : g_slice
        rc_alu_slice u_slice (
            .a   (opa[i]),
            .b   (opb[i]),
            .ci  (cy[i]),
            .ctl (ctl),
            .f   (result[i]),
            .co  (cy[i+1])
        );
    end

    assign carry_out = cy[N];

endmodule

// File: rtl/rc_alu_chk.sv
module rc_alu_chk #(
    parameter int N = 8
) (
    input logic [N-1:0] opa,
    input logic [N-1:0] opb,
    input logic [2:0]   sel,
    input logic         carry_in,
    input logic [N-1:0] result,
    input logic         carry_out
);

    localparam int W = N + 1;

    logic [W-1:0] got, ci_w, a_w, b_w, nb_w, ones_w;

    always_comb begin
        got    = {carry_out, result};
        ci_w   = W'(carry_in);
        a_w    = {1'b0, opa};
        b_w    = {1'b0, opb};
        nb_w   = {1'b0, ~opb};
        ones_w = {1'b0, {N{1'b1}}};
        if (sel == 3'b000) AST_XFER_INC: assert (got == a_w + ci_w);          // R1
        if (sel == 3'b001) AST_ADD_SUM:  assert (got == a_w + b_w + ci_w);    // R2
        if (sel == 3'b010) AST_SUB_SUM:  assert (got == a_w + nb_w + ci_w);   // R3
        if (sel == 3'b011) AST_DEC_SUM:  assert (got == a_w + ones_w + ci_w); // R4
        if (sel == 3'b100) AST_OR_BITS:  assert (result == (opa | opb));      // R5
        if (sel == 3'b101) AST_XOR_BITS: assert (result == (opa ^ opb));      // R6
        if (sel == 3'b110) AST_AND_BITS: assert (result == (opa & opb));      // R7
        if (sel == 3'b111) AST_NOT_BITS: assert (result == ~opa);             // R8
    end

endmodule

bind rc_alu rc_alu_chk #(.N(N)) u_chk (
    .opa       (opa),
    .opb       (opb),
    .sel       (sel),
    .carry_in  (carry_in),
    .result    (result),
    .carry_out (carry_out)
);

// File: tb/sim_rc_alu.sv
module sim_rc_alu;

    logic clk = 1'b0;
    always #2.5 clk = ~clk; // 200 MHz

    logic [15:0] a = '0, b = '0;
    logic [2:0]  s = '0;
    logic        ci = 1'b0;

    logic [3:0]  f4;  logic c4;
    logic [0:0]  f1;  logic c1;
    logic [15:0] f16; logic c16;

    rc_alu #(.N(4))  u0 (.opa(a[3:0]), .opb(b[3:0]), .sel(s), .carry_in(ci), .result(f4),  .carry_out(c4));
    rc_alu #(.N(1))  u1 (.opa(a[0:0]), .opb(b[0:0]), .sel(s), .carry_in(ci), .result(f1),  .carry_out(c1));
    rc_alu #(.N(16)) u2 (.opa(a),      .opb(b),      .sel(s), .carry_in(ci), .result(f16), .carry_out(c16));

    typedef struct {
        logic [2:0]  s;
        logic [31:0] e1, e4, e16; // {carry, result}
    } item_t;

    item_t q[$];
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // Reference from the function table: {carry, F} over width w.
    function automatic logic [31:0] ref_calc(int w, logic [15:0] av, logic [15:0] bv,
                                             logic [2:0] sv, logic cv);
        logic [31:0] m, x, y;
        m = (32'h1 << w) - 1;
        x = {16'h0, av} & m;
        y = {16'h0, bv} & m;
        case (sv)
            3'd0: return x + {31'h0, cv};              // R1
            3'd1: return x + y + {31'h0, cv};          // R2
            3'd2: return x + (~y & m) + {31'h0, cv};   // R3
            3'd3: return x + m + {31'h0, cv};          // R4
            3'd4: return x | y;                        // R5
            3'd5: return x ^ y;                        // R6
            3'd6: return x & y;                        // R7
            default: return ~x & m;                    // R8
        endcase
    endfunction

    function automatic string req_of(logic [2:0] sv);
        case (sv)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            3'd5: return "R6";
            3'd6: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic drive(logic [15:0] av, logic [15:0] bv, logic [2:0] sv, logic cv);
        item_t it;
        @(negedge clk);
        a = av; b = bv; s = sv; ci = cv;
        it.s   = sv;
        it.e1  = ref_calc(1,  av, bv, sv, cv);
        it.e4  = ref_calc(4,  av, bv, sv, cv);
        it.e16 = ref_calc(16, av, bv, sv, cv);
        q.push_back(it);
    endtask

    // Monitor: outputs settle half a period after the driver's edge.
    always @(posedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            string tg;
            it = q.pop_front();
            tg = req_of(it.s);
            check(tg, "F N=1 (R10)", {31'h0, f1},  {31'h0, it.e1[0]});
            check(tg, "F N=4",       {28'h0, f4},  {28'h0, it.e4[3:0]});
            check(tg, "F N=16",      {16'h0, f16}, {16'h0, it.e16[15:0]});
            if (it.s[2] == 1'b0) begin // carry meaningful only when arithmetic: R9
                check("R9", "carry N=1",  {31'h0, c1},  {31'h0, it.e1[1]});
                check("R9", "carry N=4",  {31'h0, c4},  {31'h0, it.e4[4]});
                check("R9", "carry N=16", {31'h0, c16}, {31'h0, it.e16[16]});
            end
        end
    end

    initial begin
        // Directed corners: all-ones increment (R1), zero decrement (R4).
        drive(16'hFFFF, 16'h0000, 3'd0, 1'b1);
        drive(16'h0000, 16'h1234, 3'd3, 1'b0);
        drive(16'h0000, 16'h0000, 3'd2, 1'b1);
        // Exhaustive over the low four bits, random upper bits.
        for (int sv = 0; sv < 8; sv++)
            for (int cv = 0; cv < 2; cv++)
                for (int av = 0; av < 16; av++)
                    for (int bv = 0; bv < 16; bv++)
                        drive({$urandom_range(0, 4095), 4'(av)}[15:0],
                              {$urandom_range(0, 4095), 4'(bv)}[15:0],
                              3'(sv), cv[0]);
        // Random wide vectors.
        for (int k = 0; k < 1500; k++)
            drive(16'($urandom), 16'($urandom), 3'($urandom_range(0, 7)), 1'($urandom));
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule